// File: doc/BRIEF.md
# Keyed Byte-Stream Configuration Port

Boot firmware talks to this block through two registers. A 16-bit select register names a key. An 8-bit data register then moves the chosen item one byte per access. Every access moves an internal byte offset forward by one. Items sit in on-chip storage with two parallel banks: a generic bank and an architecture-local bank. Reset fills this storage with a detection signature. A host-side load port fills it further, either one byte at a time or as a whole little-endian integer.

A key that carries the write-channel flag lets firmware write bytes into the item. The block raises a one-clock completion pulse when the last byte of a writable item is filled. The pulse carries the bank and index of that item. The offset then returns to the start, so a later write overwrites the item from byte zero.

Top module: `cfg_keyport`

## Requirements
- R1: Synchronous reset selects key 0x0000 with offset 0. Reset sets every item length to 0 and clears all data, except generic entry 0. Entry 0 holds the 4-byte signature 0x43, 0x46, 0x47, 0x4B, returned in that order. After reset `rd_data` and `done_pulse` are 0.
- R2: A cycle with `sel_we` high loads `sel_key` as the current key and clears the offset. The next read returns byte 0 of the item. Key layout: bit 15 is the bank flag, bit 14 is the write-channel flag, and bits 13:0 are the index.
- R3: If a select has index bits 13:0 at or above the entry count (16), the current key becomes the invalid value 0xFFFF. Until the next valid select, reads return 0 and writes are ignored.
- R4: A read cycle (`rd_en`) puts the byte at the current offset on `rd_data` after the clock edge and advances the offset by one. When the offset has reached the item length, or the length is 0, the read returns 0 and the offset does not move.
- R5: Key bit 15 set selects the architecture-local bank and bit 15 clear selects the generic bank. The same index in the two banks names two separate items.
- R6: A write cycle (`wr_en`) stores `wr_data` at the offset and advances the offset, but only when key bit 14 is set and the offset is below the length. Otherwise the write changes neither the data nor the offset.
- R7: If a write brings the offset up to the item length, `done_pulse` is high for the one cycle after that edge. During that cycle `done_bank` and `done_idx` give the filled item. The offset returns to 0, so further writes overwrite the item from byte 0.
- R8: A select in the same cycle as a read or write wins. The data access is dropped, and `rd_data` keeps its value. A read in the same cycle as a write wins, and the write is dropped.
- R9: `ld_we` stores `ld_data` at `ld_bank`/`ld_idx`/`ld_off`. `len_we` sets the length of that item to `len_val`, clamped to the per-item storage depth (8 bytes).
- R10: `int_we` loads `int_val` into the item least-significant byte first (byte 0 = bits 7:0). It sets the length to `int_bytes`, clamped to 8, so the bytes stream out low byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Select-register write strobe |
| sel_key | input | 16 | Key to select |
| rd_en | input | 1 | Data-register read strobe |
| rd_data | output | 8 | Byte returned by the last read |
| wr_en | input | 1 | Data-register write strobe |
| wr_data | input | 8 | Byte to write |
| ld_we | input | 1 | Host byte-load strobe |
| ld_bank | input | 1 | Host target bank |
| ld_idx | input | 4 | Host target index |
| ld_off | input | 3 | Host target byte offset |
| ld_data | input | 8 | Host byte to load |
| len_we | input | 1 | Host length-load strobe |
| len_val | input | 16 | Host item length |
| int_we | input | 1 | Host integer-load strobe |
| int_val | input | 64 | Integer stored low byte first |
| int_bytes | input | 16 | Length given to the integer item |
| done_pulse | output | 1 | One-cycle fill-complete event |
| done_bank | output | 1 | Bank of the filled item |
| done_idx | output | 4 | Index of the filled item |

## Verification
A read's byte appears on `rd_data` one clock edge after the cycle in which `rd_en` is high. A completion event appears on `done_pulse` one edge after the write that fills the item, and lasts only that one cycle. A select or write changes only internal state, so its effect is checked through the byte returned by the next read. Every access is driven on a falling edge and held for one rising edge. Results are sampled at the following falling edge, which is exactly where each registered output has settled. The cycle after a completion is also sampled, to confirm that the pulse has dropped.

// File: rtl/cfg_keyport_pkg.sv
package cfg_keyport_pkg;

    localparam int KEY_W     = 16;
    localparam int LEN_W     = 16;
    localparam int BANK_BIT  = 15;
    localparam int WRCH_BIT  = 14;
    localparam int IDXF_W    = 14;
    localparam logic [KEY_W-1:0] KEY_NONE = 16'hFFFF;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_SEL,
        ACC_RD,
        ACC_WR
    } acc_t;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic             valid;
        logic [LEN_W-1:0] off;
    } sel_state_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] len,
                                                   input int unsigned depth);
        logic [LEN_W-1:0] cap;
        cap = LEN_W'(depth);
        return (len > cap) ? cap : len;
    endfunction

endpackage

// File: rtl/cfg_keyport_sel.sv
module cfg_keyport_sel
    import cfg_keyport_pkg::*;
#(
    parameter int N_ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_we,
    input  logic [KEY_W-1:0] sel_key,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [LEN_W-1:0] item_len,
    output acc_t             acc,
    output logic [KEY_W-1:0] cur_key,
    output logic             cur_valid,
    output logic [LEN_W-1:0] cur_off,
    output logic             rd_hit,
    output logic             wr_hit,
    output logic             wr_last
);

    sel_state_t st_q, st_d;
    logic       in_range;
    logic       key_ok;

    // select wins over read, read wins over write
    always_comb begin
        if (sel_we)      acc = ACC_SEL;
        else if (rd_en)  acc = ACC_RD;
        else if (wr_en)  acc = ACC_WR;
        else             acc = ACC_IDLE;
    end

    assign key_ok   = {2'b00, sel_key[IDXF_W-1:0]} < KEY_W'(N_ENTRIES);
    assign in_range = st_q.valid && (st_q.off < item_len);
    assign rd_hit   = (acc == ACC_RD) && in_range;
    assign wr_hit   = (acc == ACC_WR) && in_range && st_q.key[WRCH_BIT];
    assign wr_last  = wr_hit && ((st_q.off + LEN_W'(1)) == item_len);

    always_comb begin
        st_d = st_q;
        unique case (acc)
            ACC_SEL: begin
                st_d.off   = '0;
                st_d.valid = key_ok;
                st_d.key   = key_ok ? sel_key : KEY_NONE;
            end
            ACC_RD: begin
                if (rd_hit) st_d.off = st_q.off + LEN_W'(1);
            end
            ACC_WR: begin
                if (wr_last)     st_d.off = '0;
                else if (wr_hit) st_d.off = st_q.off + LEN_W'(1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.key   <= '0;
            st_q.valid <= 1'b1;
            st_q.off   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_key   = st_q.key;
    assign cur_valid = st_q.valid;
    assign cur_off   = st_q.off;

endmodule

// File: rtl/cfg_keyport_store.sv
module cfg_keyport_store
    import cfg_keyport_pkg::*;
#(
    parameter int          N_ENTRIES = 16,
    parameter int          DEPTH     = 8,
    parameter int          SIG_LEN   = 4,
    parameter logic [31:0] SIG       = 32'h4B474643,
    localparam int         IDX_W     = $clog2(N_ENTRIES),
    localparam int         OFF_W     = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    // data-port side
    input  logic               rd_bank,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic [OFF_W-1:0]   rd_off,
    output logic [7:0]         rd_byte,
    output logic [LEN_W-1:0]   rd_len,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    // host side
    input  logic               ld_we,
    input  logic               ld_bank,
    input  logic [IDX_W-1:0]   ld_idx,
    input  logic [OFF_W-1:0]   ld_off,
    input  logic [7:0]         ld_data,
    input  logic               len_we,
    input  logic [LEN_W-1:0]   len_val,
    input  logic               int_we,
    input  logic [DEPTH*8-1:0] int_val,
    input  logic [LEN_W-1:0]   int_bytes
);

    logic [7:0]       mem  [2][N_ENTRIES][DEPTH];
    logic [LEN_W-1:0] lens [2][N_ENTRIES];

    assign rd_byte = mem[rd_bank][rd_idx][rd_off];
    assign rd_len  = lens[rd_bank][rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 2; b++) begin
                for (int e = 0; e < N_ENTRIES; e++) begin
                    lens[b][e] <= '0;
                    for (int k = 0; k < DEPTH; k++) mem[b][e][k] <= 8'h00;
                end
            end
            for (int k = 0; k < SIG_LEN; k++) mem[0][0][k] <= SIG[8*k +: 8];
            lens[0][0] <= LEN_W'(SIG_LEN);
        end else begin
            if (int_we) begin
                for (int k = 0; k < DEPTH; k++) mem[ld_bank][ld_idx][k] <= int_val[8*k +: 8];
                lens[ld_bank][ld_idx] <= clamp_len(int_bytes, DEPTH);
            end
            if (ld_we)  mem[ld_bank][ld_idx][ld_off] <= ld_data;
            if (len_we) lens[ld_bank][ld_idx] <= clamp_len(len_val, DEPTH);
            if (wr_en)  mem[rd_bank][rd_idx][rd_off] <= wr_data;
        end
    end

endmodule

// File: rtl/cfg_keyport.sv
module cfg_keyport
    import cfg_keyport_pkg::*;
#(
    parameter int          N_ENTRIES = 16,
    parameter int          DEPTH     = 8,
    parameter int          SIG_LEN   = 4,
    parameter logic [31:0] SIG       = 32'h4B474643,
    localparam int         IDX_W     = $clog2(N_ENTRIES),
    localparam int         OFF_W     = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel_we,
    input  logic [15:0]        sel_key,
    input  logic               rd_en,
    output logic [7:0]         rd_data,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    input  logic               ld_we,
    input  logic               ld_bank,
    input  logic [IDX_W-1:0]   ld_idx,
    input  logic [OFF_W-1:0]   ld_off,
    input  logic [7:0]         ld_data,
    input  logic               len_we,
    input  logic [15:0]        len_val,
    input  logic               int_we,
    input  logic [DEPTH*8-1:0] int_val,
    input  logic [15:0]        int_bytes,
    output logic               done_pulse,
    output logic               done_bank,
    output logic [IDX_W-1:0]   done_idx
);

    acc_t             acc;
    logic [KEY_W-1:0] cur_key;
    logic             cur_valid;
    logic [LEN_W-1:0] cur_off;
    logic [LEN_W-1:0] item_len;
    logic             rd_hit, wr_hit, wr_last;
    logic [7:0]       rd_byte;
    logic             cur_bank;
    logic [IDX_W-1:0] cur_idx;

    assign cur_bank = cur_key[BANK_BIT];
    assign cur_idx  = cur_key[IDX_W-1:0];

    cfg_keyport_sel #(.N_ENTRIES(N_ENTRIES)) u_sel (
        .clk(clk), .rst(rst),
        .sel_we(sel_we), .sel_key(sel_key), .rd_en(rd_en), .wr_en(wr_en),
        .item_len(item_len),
        .acc(acc), .cur_key(cur_key), .cur_valid(cur_valid), .cur_off(cur_off),
        .rd_hit(rd_hit), .wr_hit(wr_hit), .wr_last(wr_last)
    );

    cfg_keyport_store #(
        .N_ENTRIES(N_ENTRIES), .DEPTH(DEPTH), .SIG_LEN(SIG_LEN), .SIG(SIG)
    ) u_store (
        .clk(clk), .rst(rst),
        .rd_bank(cur_bank), .rd_idx(cur_idx), .rd_off(cur_off[OFF_W-1:0]),
        .rd_byte(rd_byte), .rd_len(item_len),
        .wr_en(wr_hit), .wr_data(wr_data),
        .ld_we(ld_we), .ld_bank(ld_bank), .ld_idx(ld_idx), .ld_off(ld_off),
        .ld_data(ld_data), .len_we(len_we), .len_val(len_val),
        .int_we(int_we), .int_val(int_val), .int_bytes(int_bytes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data    <= 8'h00;
            done_pulse <= 1'b0;
            done_bank  <= 1'b0;
            done_idx   <= '0;
        end else begin
            done_pulse <= wr_last;
            if (wr_last) begin
                done_bank <= cur_bank;
                done_idx  <= cur_idx;
            end
            if (acc == ACC_RD) rd_data <= rd_hit ? rd_byte : 8'h00;
        end
    end

endmodule

// File: rtl/cfg_keyport_chk.sv
module cfg_keyport_chk #(
    parameter int N_ENTRIES = 16,
    parameter int DEPTH     = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        sel_we,
    input logic [15:0] sel_key,
    input logic        rd_en,
    input logic        wr_en,
    input logic [7:0]  rd_data,
    input logic        done_pulse,
    input logic [15:0] cur_key,
    input logic        cur_valid,
    input logic [15:0] cur_off
);

    a_r2_sel_clears_off: assert property (@(posedge clk) disable iff (rst)
        sel_we |=> (cur_off == 16'd0));

    a_r3_invalid_key: assert property (@(posedge clk) disable iff (rst)
        (sel_we && ({2'b00, sel_key[13:0]} >= 16'(N_ENTRIES))) |=> (!cur_valid && cur_key == 16'hFFFF));

    a_r3_invalid_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !sel_we && !cur_valid) |=> (rd_data == 8'h00));

    a_r9_off_bounded: assert property (@(posedge clk) disable iff (rst)
        cur_off <= 16'(DEPTH));

    a_r6_no_wrch_keeps_off: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && !sel_we && !cur_key[14]) |=> $stable(cur_off));

    a_r7_done_follows_write: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> $past(wr_en && !rd_en && !sel_we));

    a_r8_sel_holds_rd_data: assert property (@(posedge clk) disable iff (rst)
        (sel_we && rd_en) |=> $stable(rd_data));

endmodule

bind cfg_keyport cfg_keyport_chk #(.N_ENTRIES(N_ENTRIES), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .sel_we(sel_we), .sel_key(sel_key),
    .rd_en(rd_en), .wr_en(wr_en), .rd_data(rd_data), .done_pulse(done_pulse),
    .cur_key(cur_key), .cur_valid(cur_valid), .cur_off(cur_off)
);

// File: tb/cfg_keyport_tb.sv
module cfg_keyport_tb;

    localparam logic [1:0] OP_SEL = 2'd0;
    localparam logic [1:0] OP_RD  = 2'd1;
    localparam logic [1:0] OP_WR  = 2'd2;
    localparam int NV = 34;

    // {req[3:0], op[1:0], arg[15:0], expected[7:0]}
    localparam logic [29:0] VEC [0:NV-1] = '{
        {4'd2,  OP_SEL, 16'h0001, 8'h00},
        {4'd10, OP_RD,  16'h0000, 8'h88},   // R10 low byte first
        {4'd10, OP_RD,  16'h0000, 8'h77},
        {4'd10, OP_RD,  16'h0000, 8'h66},
        {4'd2,  OP_SEL, 16'h0001, 8'h00},   // R2 reselect restarts
        {4'd2,  OP_RD,  16'h0000, 8'h88},
        {4'd5,  OP_SEL, 16'h8001, 8'h00},   // R5 local bank
        {4'd5,  OP_RD,  16'h0000, 8'hA2},
        {4'd5,  OP_RD,  16'h0000, 8'hA1},
        {4'd4,  OP_RD,  16'h0000, 8'h00},   // R4 past end
        {4'd5,  OP_SEL, 16'h0001, 8'h00},
        {4'd5,  OP_RD,  16'h0000, 8'h88},
        {4'd3,  OP_SEL, 16'h0010, 8'h00},   // R3 invalid index
        {4'd3,  OP_RD,  16'h0000, 8'h00},
        {4'd3,  OP_SEL, 16'h3FFF, 8'h00},
        {4'd3,  OP_RD,  16'h0000, 8'h00},
        {4'd6,  OP_SEL, 16'h4002, 8'h00},   // R6 writable key
        {4'd6,  OP_WR,  16'h005A, 8'h00},
        {4'd6,  OP_WR,  16'h005B, 8'h00},
        {4'd6,  OP_SEL, 16'h0002, 8'h00},
        {4'd6,  OP_RD,  16'h0000, 8'h5A},
        {4'd6,  OP_RD,  16'h0000, 8'h5B},
        {4'd4,  OP_RD,  16'h0000, 8'h00},
        {4'd4,  OP_RD,  16'h0000, 8'h00},
        {4'd9,  OP_SEL, 16'h0003, 8'h00},   // R9 clamped length 8
        {4'd9,  OP_RD,  16'h0000, 8'h30},
        {4'd9,  OP_RD,  16'h0000, 8'h31},
        {4'd9,  OP_RD,  16'h0000, 8'h32},
        {4'd9,  OP_RD,  16'h0000, 8'h33},
        {4'd9,  OP_RD,  16'h0000, 8'h34},
        {4'd9,  OP_RD,  16'h0000, 8'h35},
        {4'd9,  OP_RD,  16'h0000, 8'h36},
        {4'd9,  OP_RD,  16'h0000, 8'h37},
        {4'd9,  OP_RD,  16'h0000, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_we = 1'b0;
    logic [15:0] sel_key = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        ld_we = 1'b0;
    logic        ld_bank = 1'b0;
    logic [3:0]  ld_idx = '0;
    logic [2:0]  ld_off = '0;
    logic [7:0]  ld_data = '0;
    logic        len_we = 1'b0;
    logic [15:0] len_val = '0;
    logic        int_we = 1'b0;
    logic [63:0] int_val = '0;
    logic [15:0] int_bytes = '0;
    logic        done_pulse;
    logic        done_bank;
    logic [3:0]  done_idx;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cfg_keyport u_dut (
        .clk(clk), .rst(rst), .sel_we(sel_we), .sel_key(sel_key),
        .rd_en(rd_en), .rd_data(rd_data), .wr_en(wr_en), .wr_data(wr_data),
        .ld_we(ld_we), .ld_bank(ld_bank), .ld_idx(ld_idx), .ld_off(ld_off),
        .ld_data(ld_data), .len_we(len_we), .len_val(len_val),
        .int_we(int_we), .int_val(int_val), .int_bytes(int_bytes),
        .done_pulse(done_pulse), .done_bank(done_bank), .done_idx(done_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one access cycle: drive at falling edge, hold across one rising edge
    task automatic cyc(input logic s, input logic [15:0] k, input logic r,
                       input logic w, input logic [7:0] d);
        sel_we = s; sel_key = k; rd_en = r; wr_en = w; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        sel_we = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic sel(input logic [15:0] k);
        cyc(1'b1, k, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic rd(input logic [7:0] exp, input string req);
        cyc(1'b0, 16'h0000, 1'b1, 1'b0, 8'h00);
        chk(req, 32'(rd_data), 32'(exp), "rd_data");
    endtask

    task automatic wr(input logic [7:0] d);
        cyc(1'b0, 16'h0000, 1'b0, 1'b1, d);
    endtask

    task automatic host_cycle;
        @(posedge clk);
        @(negedge clk);
        ld_we = 1'b0; len_we = 1'b0; int_we = 1'b0;
    endtask

    task automatic do_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1 reset state and signature from key 0 without any select
        chk("R1", 32'(rd_data), 32'h0, "rd_data after reset");
        chk("R1", 32'(done_pulse), 32'h0, "done_pulse after reset");
        rd(8'h43, "R1");
        rd(8'h46, "R1");
        rd(8'h47, "R1");
        rd(8'h4B, "R1");
        rd(8'h00, "R4");

        // host loads: R10 integer, R5 local bank, R9 bytes + clamped length
        ld_bank = 1'b0; ld_idx = 4'd1; int_val = 64'h1122334455667788; int_bytes = 16'd8;
        int_we = 1'b1; host_cycle();
        ld_bank = 1'b1; ld_idx = 4'd1; int_val = 64'h000000000000A1A2; int_bytes = 16'd2;
        int_we = 1'b1; host_cycle();
        ld_bank = 1'b0; ld_idx = 4'd2; len_val = 16'd3; len_we = 1'b1; host_cycle();
        for (int i = 0; i < 8; i++) begin
            ld_bank = 1'b0; ld_idx = 4'd3; ld_off = 3'(i); ld_data = 8'(8'h30 + i);
            ld_we = 1'b1; host_cycle();
        end
        ld_bank = 1'b0; ld_idx = 4'd3; len_val = 16'd300; len_we = 1'b1; host_cycle();
        ld_bank = 1'b1; ld_idx = 4'd5; len_val = 16'd1; len_we = 1'b1; host_cycle();

        for (int v = 0; v < NV; v++) begin
            logic [3:0]  rq;
            logic [1:0]  op;
            logic [15:0] arg;
            logic [7:0]  ex;
            {rq, op, arg, ex} = VEC[v];
            case (op)
                OP_SEL: sel(arg);
                OP_WR:  wr(arg[7:0]);
                default: begin
                    cyc(1'b0, 16'h0000, 1'b1, 1'b0, 8'h00);
                    chk($sformatf("R%0d step %0d", rq, v), 32'(rd_data), 32'(ex), "rd_data");
                end
            endcase
        end

        // R7 fill completion, pulse width and wrap-around
        sel(16'h4002);
        wr(8'h01); chk("R7", 32'(done_pulse), 32'h0, "done after byte 0");
        wr(8'h02); chk("R7", 32'(done_pulse), 32'h0, "done after byte 1");
        wr(8'h03);
        chk("R7", 32'(done_pulse), 32'h1, "done after last byte");
        chk("R7", 32'(done_bank), 32'h0, "done_bank");
        chk("R7", 32'(done_idx), 32'h2, "done_idx");
        @(posedge clk); @(negedge clk);
        chk("R7", 32'(done_pulse), 32'h0, "done one cycle later");
        wr(8'h04);
        sel(16'h0002);
        rd(8'h04, "R7");
        rd(8'h02, "R7");
        rd(8'h03, "R7");

        // R6 write without write-channel bit is ignored
        sel(16'h0002);
        wr(8'hEE);
        rd(8'h04, "R6");

        // R7 on the local bank
        sel(16'hC005);
        wr(8'h77);
        chk("R7", 32'(done_pulse), 32'h1, "done local");
        chk("R7", 32'(done_bank), 32'h1, "done_bank local");
        chk("R7", 32'(done_idx), 32'h5, "done_idx local");
        sel(16'h8005);
        rd(8'h77, "R5");

        // R8 select beats read
        sel(16'h0001);
        rd(8'h88, "R8");
        rd(8'h77, "R8");
        cyc(1'b1, 16'h0001, 1'b1, 1'b0, 8'h00);
        chk("R8", 32'(rd_data), 32'h77, "rd_data held on select");
        rd(8'h88, "R8");

        // R8 read beats write
        sel(16'h4002);
        cyc(1'b0, 16'h0000, 1'b1, 1'b1, 8'h99);
        chk("R8", 32'(rd_data), 32'h04, "read wins");
        chk("R8", 32'(done_pulse), 32'h0, "no done");
        sel(16'h0002);
        rd(8'h04, "R8");
        rd(8'h02, "R8");

        // R1 reset in the middle of a stream
        sel(16'h0001);
        rd(8'h88, "R1");
        do_reset();
        chk("R1", 32'(rd_data), 32'h0, "rd_data after second reset");
        rd(8'h43, "R1");
        sel(16'h0001);
        rd(8'h00, "R1");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule